// File: doc/BRIEF.md
# Word DMA Channel with Block and Total Counting

This block is one 32-bit word DMA channel. A host loads the source address, the destination address, a total word count, a block word count, a fill word and a control word through a small register port. When the host sets the enable bit, the channel copies the programmed source, destination and total into its working registers. It then waits for its start condition. That condition is either "immediately" or a pulse on one of sixteen trigger inputs. Each start moves one block of words over a simple request/acknowledge memory port. Every word is a read followed by a write, or a write of the fill word alone in fill mode.

Two counts run side by side: the words left in the current block and the words left in the whole transfer. In a triggered transfer the block is cut short to what remains of the total. A repeat option ignores the total and keeps the channel armed. Immediate mode always finishes after exactly one block. Source and destination can each step up, step down or stay fixed. Either pointer can also be reloaded from its programmed base at every block start. When the channel finishes a transfer it clears its own enable bit, and it can signal this with a one-cycle interrupt.

Top module: `word_dma_chan`

## Requirements
- R1: Register selects are: 0 source base, 1 destination base, 2 total words, 3 block words, 4 fill word, 5 control. Only a control write that takes bit 31 from 0 to 1 copies the source base, destination base and total into the working pointers and the remaining total. Base writes made while the channel is enabled do not move the working pointers unless a reload applies.
- R2: Control bits 11:10 set the destination step. Value 0 adds 4 after each word, 1 subtracts 4, 2 keeps the address, and 3 behaves as 0.
- R3: Control bits 14:13 set the source step. Value 0 adds 4, 1 subtracts 4, and 2 keeps the address. Value 3 is fill mode: no read is issued, the source does not step, and every write carries the fill word.
- R4: Control bits 28:24 are the start mode. Values of 16 and above mean immediate: one block starts as soon as the channel is enabled. A value from 0 to 15 waits for a pulse on trig_in at that index, and pulses on other indices do nothing.
- R5: A block length of 0 is taken as 2^BLK_W words.
- R6: In a triggered mode with bit 29 clear, a block is limited to the remaining total, and a block with nothing left moves no words. Immediate mode and repeat mode (bit 29 set) are not limited by the total.
- R7: At each block start, bit 12 set reloads the working destination from the destination base, and bit 15 set reloads the working source from the source base. Otherwise both continue from where the last block left them.
- R8: At the end of an immediate block the channel clears bit 31. In a triggered mode with bit 29 clear, it clears bit 31 only when the remaining total is zero. In repeat mode bit 31 stays set and the channel waits for the next trigger.
- R9: With control bit 30 set, irq pulses high for exactly one cycle when the channel clears its own enable bit. Otherwise irq stays low.
- R10: Each non-fill word is one read at the working source, then one write at the working destination that carries the data returned with the read acknowledge. A request keeps its address, direction and data stable until mem_ready is seen with it.
- R11: busy is high from the cycle after a block starts until the cycle after its last word is acknowledged. Triggers that arrive while busy is high are ignored, and no request is issued while busy is low.
- R12: After reset every register reads 0, busy and irq are low, and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_wsel | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Host write data |
| reg_rsel | input | 3 | Register select for reads |
| reg_rdata | output | 32 | Read data for reg_rsel (combinational) |
| trig_in | input | 16 | External start triggers, one per start mode 0 to 15 |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| busy | output | 1 | A block is in progress |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the channel with BLK_W set to 4 and with 32-bit address and total widths. This lets a zeroed block length expand to a 16-word block that can be checked word by word, where the default would need millions of words. With a small memory that stalls ready on two cycles out of three, every request is held across wait cycles. Triggered and repeat runs of two or three words then show the limit to the total, the pointer continuation and the reloads across several blocks.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

    localparam int WORD_BYTES = 4;

    localparam logic [2:0] SEL_SRC   = 3'd0;
    localparam logic [2:0] SEL_DST   = 3'd1;
    localparam logic [2:0] SEL_TOTAL = 3'd2;
    localparam logic [2:0] SEL_BLOCK = 3'd3;
    localparam logic [2:0] SEL_FILL  = 3'd4;
    localparam logic [2:0] SEL_CTRL  = 3'd5;

    localparam int CB_EN      = 31;
    localparam int CB_IRQ     = 30;
    localparam int CB_RPT     = 29;
    localparam int CB_SRC_RLD = 15;
    localparam int CB_DST_RLD = 12;

    localparam logic [4:0] MODE_IMM = 5'h10;

    typedef enum logic [1:0] {
        STEP_UP   = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_FILL = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_CLOSE = 2'd3
    } state_e;

    typedef struct packed {
        logic       en;
        logic       irq_en;
        logic       rpt;
        logic [4:0] mode;
        logic       src_rld;
        step_e      src_step;
        logic       dst_rld;
        step_e      dst_step;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.en       = w[CB_EN];
        c.irq_en   = w[CB_IRQ];
        c.rpt      = w[CB_RPT];
        c.mode     = (w[28:24] > MODE_IMM) ? MODE_IMM : w[28:24];
        c.src_rld  = w[CB_SRC_RLD];
        c.src_step = step_e'(w[14:13]);
        c.dst_rld  = w[CB_DST_RLD];
        c.dst_step = (w[11:10] == 2'd3) ? STEP_UP : step_e'(w[11:10]);
        return c;
    endfunction

endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
    import wdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 32,
    parameter int BW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_sel,
    output logic [31:0]   rd_data,
    input  logic          self_clear,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [TW-1:0] total,
    output logic [BW-1:0] blk_len,
    output logic [31:0]   fill_word,
    output logic [31:0]   ctrl_word,
    output logic          en_rise
);

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (wr_sel == SEL_CTRL);
    assign en_rise  = ctrl_hit && !ctrl_word[CB_EN] && wr_data[CB_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base  <= '0;
            dst_base  <= '0;
            total     <= '0;
            blk_len   <= '0;
            fill_word <= '0;
            ctrl_word <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_SRC)   src_base  <= wr_data[AW-1:0];
            if (wr_en && wr_sel == SEL_DST)   dst_base  <= wr_data[AW-1:0];
            if (wr_en && wr_sel == SEL_TOTAL) total     <= wr_data[TW-1:0];
            if (wr_en && wr_sel == SEL_BLOCK) blk_len   <= wr_data[BW-1:0];
            if (wr_en && wr_sel == SEL_FILL)  fill_word <= wr_data;
            if (ctrl_hit) begin
                ctrl_word <= wr_data;
                if (self_clear) ctrl_word[CB_EN] <= 1'b0;
            end else if (self_clear) begin
                ctrl_word[CB_EN] <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_SRC:   rd_data[AW-1:0] = src_base;
            SEL_DST:   rd_data[AW-1:0] = dst_base;
            SEL_TOTAL: rd_data[TW-1:0] = total;
            SEL_BLOCK: rd_data[BW-1:0] = blk_len;
            SEL_FILL:  rd_data         = fill_word;
            SEL_CTRL:  rd_data         = ctrl_word;
            default:   rd_data         = '0;
        endcase
    end

endmodule

// File: rtl/wdma_addr_reg.sv
module wdma_addr_reg
    import wdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          reload,
    input  logic [AW-1:0] base,
    input  step_e         step,
    input  logic          adv,
    output logic [AW-1:0] cur
);

    localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load || reload) begin
            cur <= base;
        end else if (adv) begin
            case (step)
                STEP_UP:   cur <= cur + STRIDE;
                STEP_DOWN: cur <= cur - STRIDE;
                default:   cur <= cur;
            endcase
        end
    end

endmodule

// File: rtl/wdma_counts.sv
module wdma_counts #(
    parameter int TW = 32,
    parameter int BW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_total,
    input  logic [TW-1:0] total_in,
    input  logic [BW-1:0] blk_len,
    input  logic          limit_en,
    input  logic          blk_start,
    input  logic          word_done,
    output logic          blk_empty,
    output logic          blk_last,
    output logic          tot_zero
);

    localparam int CW = (TW > BW + 1) ? TW : BW + 1;
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] FULL_BLK = ONE << BW;

    logic [CW-1:0] blk_rem;
    logic [CW-1:0] tot_rem;
    logic [CW-1:0] blk_full;
    logic [CW-1:0] blk_eff;

    always_comb begin
        blk_full = (blk_len == '0) ? FULL_BLK : CW'(blk_len);
        blk_eff  = (limit_en && (blk_full > tot_rem)) ? tot_rem : blk_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_rem <= '0;
            blk_rem <= '0;
        end else begin
            if (load_total)     tot_rem <= CW'(total_in);
            else if (word_done) tot_rem <= tot_rem - ONE;

            if (blk_start)      blk_rem <= blk_eff;
            else if (word_done) blk_rem <= blk_rem - ONE;
        end
    end

    assign blk_empty = (blk_eff == '0);
    assign blk_last  = (blk_rem == ONE);
    assign tot_zero  = (tot_rem == '0);

endmodule

// File: rtl/wdma_seq.sv
module wdma_seq
    import wdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          fill_mode,
    input  logic          imm,
    input  logic          rpt,
    input  logic          irq_en,
    input  logic          blk_empty,
    input  logic          blk_last,
    input  logic          tot_zero,
    input  logic [AW-1:0] cur_src,
    input  logic [AW-1:0] cur_dst,
    input  logic [31:0]   fill_word,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          blk_start,
    output logic          word_done,
    output logic          self_clear,
    output logic          irq,
    output logic          busy
);

    state_e      st_q, st_d;
    logic [31:0] data_q;
    logic        irq_q;

    always_comb begin
        st_d       = st_q;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        blk_start  = 1'b0;
        word_done  = 1'b0;
        self_clear = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (go) begin
                    blk_start = 1'b1;
                    if (blk_empty)      st_d = ST_CLOSE;
                    else if (fill_mode) st_d = ST_WRITE;
                    else                st_d = ST_READ;
                end
            end
            ST_READ: begin
                mem_valid = 1'b1;
                mem_addr  = cur_src;
                if (mem_ready) st_d = ST_WRITE;
            end
            ST_WRITE: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = cur_dst;
                mem_wdata = fill_mode ? fill_word : data_q;
                if (mem_ready) begin
                    word_done = 1'b1;
                    if (blk_last)       st_d = ST_CLOSE;
                    else if (fill_mode) st_d = ST_WRITE;
                    else                st_d = ST_READ;
                end
            end
            ST_CLOSE: begin
                self_clear = imm || (!rpt && tot_zero);
                st_d       = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= self_clear && irq_en;
            if (st_q == ST_READ && mem_ready) data_q <= mem_rdata;
        end
    end

    assign irq  = irq_q;
    assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/word_dma_chan.sv
module word_dma_chan
    import wdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 32,
    parameter int BLK_W = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_wsel,
    input  logic [31:0]   reg_wdata,
    input  logic [2:0]    reg_rsel,
    output logic [31:0]   reg_rdata,
    input  logic [15:0]   trig_in,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          irq
);

    localparam int NPTR = 2;

    logic [AW-1:0]    src_base, dst_base;
    logic [TW-1:0]    total;
    logic [BLK_W-1:0] blk_len;
    logic [31:0]      fill_word, ctrl_word;
    logic             en_rise, self_clear;
    logic             blk_start, word_done;
    logic             blk_empty, blk_last, tot_zero;
    ctrl_t            cfg;
    logic             fill_mode, imm, limit_en, go;

    logic [AW-1:0] ptr_base [NPTR];
    logic [AW-1:0] ptr_cur  [NPTR];
    step_e         ptr_step [NPTR];
    logic          ptr_rld  [NPTR];
    logic          ptr_adv  [NPTR];

    wdma_regs #(.AW(AW), .TW(TW), .BW(BLK_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_we), .wr_sel(reg_wsel), .wr_data(reg_wdata),
        .rd_sel(reg_rsel), .rd_data(reg_rdata),
        .self_clear(self_clear),
        .src_base(src_base), .dst_base(dst_base), .total(total),
        .blk_len(blk_len), .fill_word(fill_word), .ctrl_word(ctrl_word),
        .en_rise(en_rise)
    );

    always_comb begin
        cfg       = decode_ctrl(ctrl_word);
        fill_mode = (cfg.src_step == STEP_FILL);
        imm       = (cfg.mode == MODE_IMM);
        limit_en  = !imm && !cfg.rpt;
        go        = cfg.en && (imm || trig_in[cfg.mode[3:0]]);

        ptr_base[0] = src_base;
        ptr_step[0] = fill_mode ? STEP_HOLD : cfg.src_step;
        ptr_rld[0]  = blk_start && cfg.src_rld;
        ptr_adv[0]  = word_done && !fill_mode;

        ptr_base[1] = dst_base;
        ptr_step[1] = cfg.dst_step;
        ptr_rld[1]  = blk_start && cfg.dst_rld;
        ptr_adv[1]  = word_done;
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        wdma_addr_reg #(.AW(AW)) u_ptr (
            .clk(clk), .rst(rst),
            .load(en_rise), .reload(ptr_rld[g]),
            .base(ptr_base[g]), .step(ptr_step[g]),
            .adv(ptr_adv[g]), .cur(ptr_cur[g])
        );
    end

    wdma_counts #(.TW(TW), .BW(BLK_W)) u_cnt (
        .clk(clk), .rst(rst),
        .load_total(en_rise), .total_in(total),
        .blk_len(blk_len), .limit_en(limit_en),
        .blk_start(blk_start), .word_done(word_done),
        .blk_empty(blk_empty), .blk_last(blk_last), .tot_zero(tot_zero)
    );

    wdma_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst),
        .go(go), .fill_mode(fill_mode), .imm(imm), .rpt(cfg.rpt),
        .irq_en(cfg.irq_en),
        .blk_empty(blk_empty), .blk_last(blk_last), .tot_zero(tot_zero),
        .cur_src(ptr_cur[0]), .cur_dst(ptr_cur[1]), .fill_word(fill_word),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .blk_start(blk_start), .word_done(word_done),
        .self_clear(self_clear), .irq(irq), .busy(busy)
    );

endmodule

// File: rtl/wdma_chk.sv
module wdma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_valid,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready,
    input logic          busy,
    input logic          irq,
    input logic          fill_mode,
    input logic          en_bit
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata))) // R10
        else $error("request changed before ready");

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) // R9
        else $error("irq longer than one cycle");

    AST_IRQ_AT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!en_bit && !busy && $past(busy))) // R9
        else $error("irq without the enable being cleared at block end");

    AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && fill_mode) |-> mem_write) // R3
        else $error("read issued in fill mode");

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_valid) // R11
        else $error("request while not busy");

endmodule

bind word_dma_chan wdma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst),
    .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .busy(busy), .irq(irq), .fill_mode(fill_mode),
    .en_bit(ctrl_word[31])
);

// File: tb/sim_word_dma_chan.sv
module sim_word_dma_chan;
    import wdma_pkg::*;

    localparam int AW = 32;
    localparam int TW = 32;
    localparam int BW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_wsel = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_rsel = '0;
    logic [31:0] reg_rdata;
    logic [15:0] trig = '0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [256];
    int          log_n = 0;
    logic [31:0] log_addr [1024];
    logic        log_we   [1024];
    logic [31:0] log_data [1024];
    int          irq_n = 0;
    logic        stall = 1'b0;
    int          phase = 0;

    always #10 clk = ~clk;

    word_dma_chan #(.AW(AW), .TW(TW), .BLK_W(BW)) u0 (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .trig_in(trig),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .irq(irq)
    );

    // memory model: decides ready at the falling edge, the handshake completes at the next rising edge
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
            mem_ready = 1'b0;
        end else begin
            phase     = (phase + 1) % 3;
            mem_ready = !stall || (phase == 0);
            if (irq) irq_n++;
            if (mem_valid && mem_ready && log_n < 1024) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_write;
                if (mem_write) begin
                    mem[mem_addr[9:2]] = mem_wdata;
                    log_data[log_n]    = mem_wdata;
                end else begin
                    mem_rdata       = mem[mem_addr[9:2]];
                    log_data[log_n] = mem_rdata;
                end
                log_n++;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wsel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] s, output logic [31:0] v);
        reg_rsel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        trig[idx] = 1'b1;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic wait_done();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input bit en, input bit ie, input bit rp,
                                       input logic [4:0] mode, input bit srl,
                                       input logic [1:0] ss, input bit drl,
                                       input logic [1:0] ds);
        logic [31:0] w = '0;
        w[31] = en; w[30] = ie; w[29] = rp; w[28:24] = mode;
        w[15] = srl; w[14:13] = ss; w[12] = drl; w[11:10] = ds;
        return w;
    endfunction

    task automatic setup(input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] tot, input logic [31:0] blk);
        hw(SEL_SRC, s); hw(SEL_DST, d); hw(SEL_TOTAL, tot); hw(SEL_BLOCK, blk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R12", "busy", 32'(busy), 0);
        check("R12", "mem_valid", 32'(mem_valid), 0);
        check("R12", "irq", 32'(irq), 0);
        hr(SEL_CTRL, v);  check("R12", "ctrl", v, 0);
        hr(SEL_SRC, v);   check("R12", "src", v, 0);
        hr(SEL_BLOCK, v); check("R12", "block", v, 0);
    endtask

    task automatic t_immediate();
        int b = log_n; int i0 = irq_n; logic [31:0] v;
        stall = 1'b1;
        setup(32'h40, 32'h200, 32'd1, 32'd4);
        hw(SEL_CTRL, mk(1, 1, 0, 5'h1F, 0, 2'd0, 0, 2'd0));
        wait_done();
        check("R6", "imm words not limited", 32'(log_n - b), 8);
        for (int k = 0; k < 4; k++) begin
            check("R10", "read dir", 32'(log_we[b+2*k]), 0);
            check("R1", "read addr", log_addr[b+2*k], 32'h40 + 4*k);
            check("R10", "write dir", 32'(log_we[b+2*k+1]), 1);
            check("R2", "write addr", log_addr[b+2*k+1], 32'h200 + 4*k);
            check("R10", "write data", log_data[b+2*k+1], 32'hA000_0010 + k);
        end
        hr(SEL_CTRL, v);
        check("R8", "imm enable cleared", 32'(v[31]), 0);
        check("R9", "irq count", 32'(irq_n - i0), 1);
        check("R4", "mode clamp idle after", 32'(busy), 0);
    endtask

    task automatic t_steps();
        int b = log_n; int i0 = irq_n;
        setup(32'h80, 32'h300, 32'd0, 32'd3);
        hw(SEL_CTRL, mk(1, 0, 0, 5'h10, 0, 2'd2, 0, 2'd1));
        wait_done();
        check("R3", "fixed src words", 32'(log_n - b), 6);
        for (int k = 0; k < 3; k++) begin
            check("R3", "fixed src addr", log_addr[b+2*k], 32'h80);
            check("R2", "dec dst addr", log_addr[b+2*k+1], 32'h300 - 4*k);
            check("R2", "dec dst data", log_data[b+2*k+1], 32'hA000_0020);
        end
        check("R9", "no irq when disabled", 32'(irq_n - i0), 0);

        b = log_n;
        setup(32'hC0, 32'h380, 32'd0, 32'd2);
        hw(SEL_CTRL, mk(1, 0, 0, 5'h10, 0, 2'd1, 0, 2'd3));
        wait_done();
        check("R3", "dec src addr0", log_addr[b], 32'hC0);
        check("R3", "dec src addr1", log_addr[b+2], 32'hBC);
        check("R2", "mode3 dst addr0", log_addr[b+1], 32'h380);
        check("R2", "mode3 dst addr1", log_addr[b+3], 32'h384);
        check("R10", "mode3 data1", log_data[b+3], 32'hA000_002F);

        b = log_n;
        setup(32'h10, 32'h3C0, 32'd0, 32'd2);
        hw(SEL_CTRL, mk(1, 0, 0, 5'h10, 0, 2'd0, 0, 2'd2));
        wait_done();
        check("R2", "fixed dst addr0", log_addr[b+1], 32'h3C0);
        check("R2", "fixed dst addr1", log_addr[b+3], 32'h3C0);
        check("R2", "fixed dst data1", log_data[b+3], 32'hA000_0005);
    endtask

    task automatic t_fill();
        int b = log_n; int i0 = irq_n;
        setup(32'h20, 32'h100, 32'd0, 32'd5);
        hw(SEL_FILL, 32'hDEAD_BEEF);
        hw(SEL_CTRL, mk(1, 1, 0, 5'h10, 0, 2'd3, 0, 2'd0));
        wait_done();
        check("R3", "fill entries", 32'(log_n - b), 5);
        for (int k = 0; k < 5; k++) begin
            check("R3", "fill is write", 32'(log_we[b+k]), 1);
            check("R3", "fill addr", log_addr[b+k], 32'h100 + 4*k);
            check("R3", "fill data", log_data[b+k], 32'hDEAD_BEEF);
        end
        check("R9", "fill irq", 32'(irq_n - i0), 1);
    endtask

    task automatic t_trigger();
        int b = log_n; int i0 = irq_n; logic [31:0] v;
        setup(32'h00, 32'h240, 32'd5, 32'd2);
        hw(SEL_CTRL, mk(1, 1, 0, 5'd3, 0, 2'd0, 0, 2'd0));
        repeat (6) @(negedge clk);
        check("R4", "waits for trigger", 32'(log_n - b), 0);
        check("R4", "not busy before trigger", 32'(busy), 0);
        pulse(2);
        repeat (4) @(negedge clk);
        check("R4", "other trigger ignored", 32'(log_n - b), 0);
        pulse(3);
        check("R11", "busy after start", 32'(busy), 1);
        pulse(3);
        wait_done();
        check("R11", "trigger while busy ignored", 32'(log_n - b), 4);
        hr(SEL_CTRL, v);
        check("R8", "still enabled mid total", 32'(v[31]), 1);
        check("R9", "no irq mid total", 32'(irq_n - i0), 0);
        hw(SEL_DST, 32'h3F0);
        pulse(3);
        wait_done();
        check("R7", "second block words", 32'(log_n - b), 8);
        pulse(3);
        wait_done();
        check("R6", "limited last block", 32'(log_n - b), 10);
        for (int k = 0; k < 5; k++) begin
            check("R1", "continued dst addr", log_addr[b+2*k+1], 32'h240 + 4*k);
            check("R7", "continued src data", log_data[b+2*k+1], 32'hA000_0000 + k);
        end
        hr(SEL_CTRL, v);
        check("R8", "enable cleared at total zero", 32'(v[31]), 0);
        check("R9", "irq at total zero", 32'(irq_n - i0), 1);
    endtask

    task automatic t_repeat();
        int b = log_n; int i0 = irq_n; logic [31:0] v;
        setup(32'h60, 32'h280, 32'd1, 32'd3);
        hw(SEL_CTRL, mk(1, 1, 1, 5'd5, 0, 2'd0, 1, 2'd0));
        pulse(5); wait_done();
        pulse(5); wait_done();
        check("R6", "repeat ignores total", 32'(log_n - b), 12);
        for (int k = 0; k < 3; k++) begin
            check("R7", "src continues", log_addr[b+6+2*k], 32'h6C + 4*k);
            check("R7", "dst reloaded", log_addr[b+6+2*k+1], 32'h280 + 4*k);
            check("R10", "repeat data", log_data[b+6+2*k+1], 32'hA000_001B + k);
        end
        hr(SEL_CTRL, v);
        check("R8", "repeat stays enabled", 32'(v[31]), 1);
        check("R9", "no irq in repeat", 32'(irq_n - i0), 0);
        hw(SEL_CTRL, 32'h0);

        b = log_n;
        setup(32'h08, 32'h2C0, 32'd0, 32'd2);
        hw(SEL_CTRL, mk(1, 0, 1, 5'd7, 1, 2'd0, 0, 2'd0));
        pulse(7); wait_done();
        pulse(7); wait_done();
        check("R7", "src reloaded", log_addr[b+4], 32'h08);
        check("R7", "src reloaded 2", log_addr[b+6], 32'h0C);
        check("R7", "dst continues", log_addr[b+5], 32'h2C8);
        check("R7", "dst continues 2", log_addr[b+7], 32'h2CC);
        hw(SEL_CTRL, 32'h0);
    endtask

    task automatic t_zero_total();
        int b = log_n; int i0 = irq_n; logic [31:0] v;
        setup(32'h00, 32'h3A0, 32'd0, 32'd3);
        hw(SEL_CTRL, mk(1, 1, 0, 5'd1, 0, 2'd0, 0, 2'd0));
        pulse(1);
        wait_done();
        check("R6", "empty block moves nothing", 32'(log_n - b), 0);
        hr(SEL_CTRL, v);
        check("R8", "empty block clears enable", 32'(v[31]), 0);
        check("R9", "empty block irq", 32'(irq_n - i0), 1);
    endtask

    task automatic t_zero_block();
        int b = log_n;
        stall = 1'b0;
        setup(32'h00, 32'h340, 32'd100, 32'd0);
        hw(SEL_CTRL, mk(1, 0, 0, 5'h10, 0, 2'd0, 0, 2'd0));
        wait_done();
        check("R5", "zero block length words", 32'(log_n - b), 32);
        check("R5", "last dst addr", log_addr[b+31], 32'h37C);
        check("R5", "last data", log_data[b+31], 32'hA000_000F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_steps();
        t_fill();
        t_trigger();
        t_repeat();
        t_zero_total();
        t_zero_block();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule